// File: doc/BRIEF.md
# Dither-Correlating Segmental-Offset Estimator

This block learns, in the background, the digital weight of the first-stage digit of a redundant pipelined converter. It runs a 15-bit pseudo-random sequence and presents its current bit to the analog sub-converter, which uses it as a ±1 random shift of its decision threshold. Each accepted sample brings the first-stage digit (−1, 0 or +1) and the back-end code. The back-end code has its 1/4, 1/8, 1/16 … digit weights already summed into output-LSB units. The block multiplies the digit by the current offset estimate, adds the back-end code and registers the saturated sum as the corrected output.

For the same sample, the corrected value multiplied by the dither sign (T = +1 when the dither bit is 1) is added to the estimate. The step size is a programmable power of two. The estimate stops moving once the long-run average of output × dither is zero, because an ideal converter's output carries no trace of the dither. The dither acts only on the comparator thresholds, so it is never subtracted from the output.

The block has a two-state controller. TRACK is the reset state, in which the estimate is updated. HOLD freezes the estimate while correction goes on. The transition FREEZE_ON (TRACK→HOLD) is taken at the first clock edge at which `freeze` is high. FREEZE_OFF (HOLD→TRACK) is taken at the first edge at which it is low. Otherwise each state stays put.

Top module: `seg_offset_lms`

## Requirements
- R1: After reset `dither_bit` is 1 (bit 14 of the seed 15'h4A5B), `offset_est` is 0, `corr_valid` is 0 and `corr_data` is 0.
- R2: The dither register S (15 bits) loads {S[13:0], S[14]^S[13]} on every clock edge at which `smp_valid` is 1, and holds at every other edge. `dither_bit` is S[14], and its value before the edge is the T of that sample.
- R3: For a sample accepted at edge n, `corr_valid` is 1 after edge n and 0 after any edge without a sample. After edge n `corr_data` holds digit·E + backend_code, where E is the `offset_est` value before edge n. The digit code is 2'b01 = +1, 2'b11 = −1, 2'b00 = 0, and 2'b10 is never sent.
- R4: In TRACK, a sample adds T·((D·256) >>> `mu_shift`) to the internal estimate. D is the corrected value of that sample, the estimate has 8 fraction bits, and `offset_est` is the estimate >>> 8 (floor).
- R5: The internal 24-bit estimate saturates at 8388607 and −8388608 instead of wrapping, so `offset_est` stays within 32767 … −32768.
- R6: The controller enters HOLD one edge after `freeze` rises and leaves it one edge after `freeze` falls. In HOLD, samples leave `offset_est` unchanged, while `corr_data` and the dither sequence behave as in TRACK.
- R7: `corr_data` saturates at 32767 and −32768 when digit·E + backend_code falls outside the 16-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A sample is accepted at this edge |
| stage_digit | input | 2 | First-stage digit, signed code |
| backend_code | input | 14 | Back-end code in output LSBs, two's complement |
| mu_shift | input | 4 | Step-size right shift |
| freeze | input | 1 | Hold the estimate |
| dither_bit | output | 1 | Current dither bit to the sub-converter (1 = +1) |
| corr_valid | output | 1 | Corrected sample present |
| corr_data | output | 16 | Corrected output, two's complement |
| offset_est | output | 16 | Integer part of the offset estimate |

## Verification
The assertions assume that the digit code 2'b10 never arrives with `smp_valid`. They also assume that `mu_shift` is stable during the edge that takes a sample. The monotonic-step checks further assume that the product sign seen by the update is the sign of the corrected value times T. The stimulus drives only the three legal digit codes, changes inputs only on the falling edge, and chooses the sign of the back-end code from the dither bit when it has to push the estimate into either rail.

// File: rtl/seg_cal_pkg.sv
package seg_cal_pkg;
    localparam int PRBS_W = 15;
    localparam int TAP_HI = 14;
    localparam int TAP_LO = 13;

    typedef enum logic {
        ST_TRACK = 1'b0,
        ST_HOLD  = 1'b1
    } cal_state_e;

    localparam logic [1:0] DIG_POS  = 2'b01;
    localparam logic [1:0] DIG_NEG  = 2'b11;
    localparam logic [1:0] DIG_ZERO = 2'b00;
endpackage

// File: rtl/seg_dither_prbs.sv
module seg_dither_prbs
    import seg_cal_pkg::*;
#(
    parameter logic [PRBS_W-1:0] SEED = 15'h4A5B
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic dither_bit
);
    logic [PRBS_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= SEED;
        else if (adv)
            sr_q <= {sr_q[PRBS_W-2:0], sr_q[TAP_HI] ^ sr_q[TAP_LO]};
    end

    assign dither_bit = sr_q[TAP_HI];

    // R2
    prbs_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q != '0);
    // R2
    prbs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(sr_q));
endmodule

// File: rtl/seg_correct.sv
module seg_correct
    import seg_cal_pkg::*;
#(
    parameter int OUT_W = 16,
    parameter int BE_W  = 14
) (
    input  logic [1:0]       digit,
    input  logic [OUT_W-1:0] est_int,
    input  logic [BE_W-1:0]  backend,
    output logic [OUT_W-1:0] corr
);
    localparam int SUM_W = OUT_W + 2;
    localparam logic signed [SUM_W-1:0] HI = {3'b000, {(OUT_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] LO = {3'b111, {(OUT_W-1){1'b0}}};

    logic signed [SUM_W-1:0] est_ext, term, be_ext, sum;

    always_comb begin
        est_ext = {{2{est_int[OUT_W-1]}}, est_int};
        be_ext  = {{(SUM_W-BE_W){backend[BE_W-1]}}, backend};
        unique case (digit)
            DIG_POS: term = est_ext;
            DIG_NEG: term = -est_ext;
            default: term = '0;
        endcase
        sum = term + be_ext;
        if (sum > HI)
            corr = HI[OUT_W-1:0];
        else if (sum < LO)
            corr = LO[OUT_W-1:0];
        else
            corr = sum[OUT_W-1:0];
    end
endmodule

// File: rtl/seg_lms_update.sv
module seg_lms_update #(
    parameter int OUT_W = 16,
    parameter int GUARD = 8,
    parameter int MU_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic             t_pos,
    input  logic [OUT_W-1:0] corr,
    input  logic [MU_W-1:0]  mu_shift,
    output logic [OUT_W-1:0] est_int
);
    localparam int EST_W = OUT_W + GUARD;
    localparam int ACC_W = EST_W + 1;
    localparam logic signed [ACC_W-1:0] HI = {2'b00, {(EST_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] LO = {2'b11, {(EST_W-1){1'b0}}};

    logic signed [EST_W-1:0] est_q, scaled, shifted, est_d;
    logic signed [ACC_W-1:0] step_ext, est_ext, nxt;

    always_comb begin
        scaled   = {corr, {GUARD{1'b0}}};
        shifted  = scaled >>> mu_shift;
        step_ext = {shifted[EST_W-1], shifted};
        est_ext  = {est_q[EST_W-1], est_q};
        nxt      = t_pos ? (est_ext + step_ext) : (est_ext - step_ext);
        if (nxt > HI)
            est_d = HI[EST_W-1:0];
        else if (nxt < LO)
            est_d = LO[EST_W-1:0];
        else
            est_d = nxt[EST_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            est_q <= '0;
        else if (upd_en)
            est_q <= est_d;
    end

    assign est_int = est_q[EST_W-1:GUARD];

    // R5
    up_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && t_pos && !corr[OUT_W-1]) |=> est_q >= $past(est_q));
    // R5
    down_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !t_pos && !corr[OUT_W-1]) |=> est_q <= $past(est_q));
    // R6
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(est_q));
endmodule

// File: rtl/seg_offset_lms.sv
module seg_offset_lms
    import seg_cal_pkg::*;
#(
    parameter int                OUT_W     = 16,
    parameter int                BE_W      = 14,
    parameter int                GUARD     = 8,
    parameter int                MU_W      = 4,
    parameter logic [PRBS_W-1:0] PRBS_SEED = 15'h4A5B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [1:0]       stage_digit,
    input  logic [BE_W-1:0]  backend_code,
    input  logic [MU_W-1:0]  mu_shift,
    input  logic             freeze,
    output logic             dither_bit,
    output logic             corr_valid,
    output logic [OUT_W-1:0] corr_data,
    output logic [OUT_W-1:0] offset_est
);
    cal_state_e       state_q, state_d;
    logic             upd_en;
    logic [OUT_W-1:0] corr_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_TRACK;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_TRACK: state_d = freeze ? ST_HOLD : ST_TRACK;
            ST_HOLD:  state_d = freeze ? ST_HOLD : ST_TRACK;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_TRACK: upd_en = smp_valid;
            ST_HOLD:  upd_en = 1'b0;
        endcase
    end

    seg_dither_prbs #(.SEED(PRBS_SEED)) u_prbs (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (smp_valid),
        .dither_bit (dither_bit)
    );

    seg_correct #(.OUT_W(OUT_W), .BE_W(BE_W)) u_corr (
        .digit   (stage_digit),
        .est_int (offset_est),
        .backend (backend_code),
        .corr    (corr_now)
    );

    seg_lms_update #(.OUT_W(OUT_W), .GUARD(GUARD), .MU_W(MU_W)) u_lms (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .t_pos    (dither_bit),
        .corr     (corr_now),
        .mu_shift (mu_shift),
        .est_int  (offset_est)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            corr_valid <= 1'b0;
            corr_data  <= '0;
        end else begin
            corr_valid <= smp_valid;
            if (smp_valid)
                corr_data <= corr_now;
        end
    end

    // R3
    digit_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> stage_digit != 2'b10);
    // R3
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> corr_valid);
    // R3
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !corr_valid);
    // R6
    hold_est_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> offset_est == $past(offset_est));
    // R6
    freeze_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> state_q == ST_HOLD);
endmodule

// File: tb/test_seg_offset_lms.sv
module test_seg_offset_lms;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [1:0]  stage_digit = 2'b00;
    logic [13:0] backend_code = '0;
    logic [3:0]  mu_shift = '0;
    logic        freeze = 1'b0;
    logic        dither_bit, corr_valid;
    logic [15:0] corr_data, offset_est;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [14:0] m_sr;
    longint      m_est;
    bit          m_frozen;

    always #5 clk = ~clk;

    seg_offset_lms i_seg_offset_lms (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .stage_digit(stage_digit), .backend_code(backend_code),
        .mu_shift(mu_shift), .freeze(freeze), .dither_bit(dither_bit),
        .corr_valid(corr_valid), .corr_data(corr_data), .offset_est(offset_est)
    );

    // vector: {digit code[19:18], backend[17:4], mu_shift[3:0]}
    localparam int NV = 12;
    localparam logic [19:0] VEC [NV] = '{
        {2'b01, 14'(3000),  4'd0}, {2'b11, 14'(-2000), 4'd1},
        {2'b01, 14'(500),   4'd3}, {2'b00, 14'(-7000), 4'd2},
        {2'b11, 14'(8191),  4'd4}, {2'b01, 14'(-8192), 4'd0},
        {2'b00, 14'(1234),  4'd5}, {2'b01, 14'(100),   4'd8},
        {2'b11, 14'(-50),   4'd6}, {2'b01, 14'(4000),  4'd1},
        {2'b11, 14'(3000),  4'd2}, {2'b00, 14'(-1),    4'd15}
    };

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat(input longint v, input int w);
        longint hi = (longint'(1) << (w - 1)) - 1;
        longint lo = -hi - 1;
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    function automatic longint est_int_m();
        return m_est >>> 8;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_valid = 1'b0; freeze = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_sr = 15'h4A5B; m_est = 0; m_frozen = 1'b0;
    endtask

    // entered at a falling edge; returns at the next falling edge
    task automatic do_sample(input logic [1:0] dg, input logic [13:0] be, input logic [3:0] mu);
        longint dval, d_exp, step;
        int     dig;
        bit     t_pos;
        chk("R2 dither before sample", dither_bit, m_sr[14]);
        dig = (dg == 2'b01) ? 1 : ((dg == 2'b11) ? -1 : 0);
        t_pos = m_sr[14];
        dval = longint'(dig) * est_int_m() + longint'($signed(be));
        d_exp = sat(dval, 16);
        step = (d_exp * 256) >>> mu;
        if (!m_frozen)
            m_est = sat(t_pos ? m_est + step : m_est - step, 24);
        m_sr = {m_sr[13:0], m_sr[14] ^ m_sr[13]};
        stage_digit = dg; backend_code = be; mu_shift = mu; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R3 corr_valid", corr_valid, 1);
        chk("R3/R7 corr_data", longint'($signed(corr_data)), d_exp);
        chk("R4/R5/R6 offset_est", longint'($signed(offset_est)), est_int_m());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1
        chk("R1 dither_bit", dither_bit, 1);
        chk("R1 offset_est", offset_est, 0);
        chk("R1 corr_valid", corr_valid, 0);
        chk("R1 corr_data", corr_data, 0);

        for (int i = 0; i < NV; i++)
            do_sample(VEC[i][19:18], VEC[i][17:4], VEC[i][3:0]);

        // R2 / R3: an idle cycle moves neither dither nor estimate
        @(negedge clk);
        chk("R3 valid drops when idle", corr_valid, 0);
        chk("R2 dither holds when idle", dither_bit, m_sr[14]);
        chk("R4 estimate holds when idle", longint'($signed(offset_est)), est_int_m());

        // R6: freeze, correction continues
        freeze = 1'b1;
        @(negedge clk);
        m_frozen = 1'b1;
        for (int i = 0; i < 4; i++)
            do_sample(2'b01, 14'(1500 + 700 * i), 4'd0);
        chk("R6 estimate frozen", longint'($signed(offset_est)), est_int_m());
        freeze = 1'b0;
        @(negedge clk);
        m_frozen = 1'b0;
        do_sample(2'b11, 14'(2500), 4'd0);

        // R5: drive estimate into both rails
        do_reset();
        for (int i = 0; i < 8; i++)
            do_sample(2'b00, dither_bit ? 14'(8191) : 14'(-8191), 4'd0);
        chk("R5 upper rail", longint'($signed(offset_est)), 32767);
        for (int i = 0; i < 10; i++)
            do_sample(2'b00, dither_bit ? 14'(-8191) : 14'(8191), 4'd0);
        chk("R5 lower rail", longint'($signed(offset_est)), -32768);

        // R7: corrected-output saturation with estimate at -32768
        freeze = 1'b1;
        @(negedge clk);
        m_frozen = 1'b1;
        do_sample(2'b11, 14'(8191), 4'd0);
        chk("R7 corr clamps high", longint'($signed(corr_data)), 32767);
        do_sample(2'b01, 14'(-8192), 4'd0);
        chk("R7 corr clamps low", longint'($signed(corr_data)), -32768);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule